// File: doc/BRIEF.md
# GPIO Port Register File with Per-Pin Masked Writes

This block is the register file for one eight-pin general-purpose I/O port on a simple 32-bit register bus. It holds three control registers. The first is a per-pin ownership bit, called configure: when it is set, the pin is controlled by this block. The second is a per-pin direction bit, called drive-enable. The third is a per-pin output level. The block also returns the pad inputs through a synchronizer, as a read-only register. Software reads each control register as a whole byte.

Each control register has a second address, called its masked alias. A write to the alias carries a per-pin mask in data bits [15:8] and new pin values in bits [7:0]. Only the pins whose mask bit is 1 take the new value. Software can therefore change one pin in a single write, with no read-modify-write sequence, and cannot disturb pins that other agents own. The pad pins are driven only when both the configure bit and the drive-enable bit are set.

A bus write takes effect at the clock edge where `bus_wr_en` is sampled high. Read data is registered: it appears on `bus_rdata` in the cycle after `bus_rd_en`, and it is zero when no read was requested. The access path has no state machine. Every access completes in a fixed single cycle, so the logic consists of decode, update and a registered read multiplexer.

Top module: `gpio_port_regs`

## Requirements
- R1: After synchronous reset, every control register is 0, `pad_oe` is 0, `pad_out` is 0 and `bus_rdata` is 0.
- R2: A write to a direct address loads data bits [7:0] into the whole register. The direct addresses are configure 0x00, drive-enable 0x10 and output level 0x20. A read of the same address returns that byte.
- R3: A write to a masked alias uses data[15:8] as the mask and data[7:0] as the values. A pin whose mask bit is 1 takes its value bit, and a pin whose mask bit is 0 keeps its old state. The alias addresses are ALIAS_OFS + 0x00, 0x10 and 0x20, with ALIAS_OFS = 0x80 by default.
- R4: A read of any masked alias address returns 0.
- R5: A read of an unmapped address returns 0. A write to an unmapped address changes no register.
- R6: A read of address 0x30 returns `pad_in` delayed by a two-flop synchronizer. A value applied before the read-issue edge N becomes visible to a read issued at edge N+2. Writes to 0x30 change no register.
- R7: `pad_oe[i]` is 1 exactly when configure bit i and drive-enable bit i are both 1.
- R8: `pad_out` always equals the output-level register.
- R9: `bus_rdata` is updated one cycle after `bus_rd_en` is sampled. It reads 0 in every cycle that follows a cycle without a read. Bits [31:8] are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd_en | input | 1 | Read strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (8) | Byte address within the port |
| bus_wdata | input | 32 | Write data; [15:8] is the mask and [7:0] the values on aliases |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS (8) | Asynchronous pad inputs |
| pad_out | output | NUM_PINS (8) | Pad output level |
| pad_oe | output | NUM_PINS (8) | Pad drive enable; a pad is tri-stated when this bit is 0 |

## Verification
The bench builds the block with its default parameters: eight pins, an eight-bit address and the alias offset at 0x80. At this size every one of the 256 mask values can be swept through each of the three masked aliases, with the new values generated arithmetically from the mask. Each result is checked against a byte model of the registers, through both the pads and readback. The configure register is also swept over all 256 values while drive-enable follows a derived pattern, which checks the drive gating on every pin. Directed sequences cover the two-cycle input latency, alias and unmapped reads, and writes to the read-only and unmapped addresses.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Which register an access targets
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CNF,
        SEL_OE,
        SEL_OUT,
        SEL_IN
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     masked;
    } access_t;

    localparam int unsigned NUM_CTRL   = 3;
    localparam int unsigned MASK_LSB   = 8;
    localparam int unsigned OFS_CNF    = 'h00;
    localparam int unsigned OFS_OE     = 'h10;
    localparam int unsigned OFS_OUT    = 'h20;
    localparam int unsigned OFS_IN     = 'h30;

    // Control register index -> selector (0 configure, 1 drive-enable, 2 level)
    function automatic reg_sel_e ctrl_sel(input int unsigned idx);
        unique case (idx)
            0:       return SEL_CNF;
            1:       return SEL_OE;
            default: return SEL_OUT;
        endcase
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned ALIAS_OFS = 'h80
) (
    input  logic [ADDR_W-1:0] addr,
    output access_t           acc
);
    localparam logic [ADDR_W-1:0] A_CNF  = ADDR_W'(OFS_CNF);
    localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(OFS_OE);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);
    localparam logic [ADDR_W-1:0] M_CNF  = ADDR_W'(ALIAS_OFS + OFS_CNF);
    localparam logic [ADDR_W-1:0] M_OE   = ADDR_W'(ALIAS_OFS + OFS_OE);
    localparam logic [ADDR_W-1:0] M_OUT  = ADDR_W'(ALIAS_OFS + OFS_OUT);

    always_comb begin
        acc = '{sel: SEL_NONE, masked: 1'b0};
        if      (addr == A_CNF) acc.sel = SEL_CNF;
        else if (addr == A_OE)  acc.sel = SEL_OE;
        else if (addr == A_OUT) acc.sel = SEL_OUT;
        else if (addr == A_IN)  acc.sel = SEL_IN;
        else if (addr == M_CNF) acc = '{sel: SEL_CNF, masked: 1'b1};
        else if (addr == M_OE)  acc = '{sel: SEL_OE,  masked: 1'b1};
        else if (addr == M_OUT) acc = '{sel: SEL_OUT, masked: 1'b1};
    end

endmodule

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_full,
    input  logic                wr_masked,
    input  logic [31:0]         wdata,
    output logic [NUM_PINS-1:0] q
);
    logic [NUM_PINS-1:0] mask, vals;

    assign vals = wdata[NUM_PINS-1:0];
    assign mask = wdata[MASK_LSB +: NUM_PINS];

    always_ff @(posedge clk) begin
        if (rst)            q <= '0;
        else if (wr_full)   q <= vals;
        else if (wr_masked) q <= (q & ~mask) | (vals & mask);
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] d,
    output logic [NUM_PINS-1:0] q
);
    logic [NUM_PINS-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 8,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned ALIAS_OFS   = 'h80,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr_en,
    input  logic                bus_rd_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    access_t             acc;
    logic [NUM_PINS-1:0] ctrl_q [NUM_CTRL];
    logic [NUM_PINS-1:0] in_sync;
    logic [NUM_PINS-1:0] rd_byte;

    gpio_addr_decode #(
        .ADDR_W    (ADDR_W),
        .ALIAS_OFS (ALIAS_OFS)
    ) u_dec (
        .addr (bus_addr),
        .acc  (acc)
    );

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
        logic hit;
        assign hit = bus_wr_en && (acc.sel == ctrl_sel(i));
        gpio_ctrl_reg #(.NUM_PINS(NUM_PINS)) u_reg (
            .clk       (clk),
            .rst       (rst),
            .wr_full   (hit && !acc.masked),
            .wr_masked (hit && acc.masked),
            .wdata     (bus_wdata),
            .q         (ctrl_q[i])
        );
    end

    gpio_in_sync #(
        .NUM_PINS (NUM_PINS),
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (in_sync)
    );

    // Read selection: aliases and unmapped addresses read as zero
    always_comb begin
        rd_byte = '0;
        if (!acc.masked) begin
            unique case (acc.sel)
                SEL_CNF: rd_byte = ctrl_q[0];
                SEL_OE:  rd_byte = ctrl_q[1];
                SEL_OUT: rd_byte = ctrl_q[2];
                SEL_IN:  rd_byte = in_sync;
                default: rd_byte = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= 32'(rd_byte);
        else                bus_rdata <= '0;
    end

    assign pad_out = ctrl_q[2];
    assign pad_oe  = ctrl_q[0] & ctrl_q[1];

endmodule

// File: rtl/gpio_port_regs_checker.sv
module gpio_port_regs_checker #(
    parameter int unsigned NUM_PINS  = 8,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned ALIAS_OFS = 'h80
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wr_en,
    input logic                bus_rd_en,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe
);
    localparam logic [ADDR_W-1:0] D_OUT = ADDR_W'('h20);
    localparam logic [ADDR_W-1:0] D_IN  = ADDR_W'('h30);
    localparam logic [ADDR_W-1:0] M_CNF = ADDR_W'(ALIAS_OFS);
    localparam logic [ADDR_W-1:0] M_OE  = ADDR_W'(ALIAS_OFS + 'h10);
    localparam logic [ADDR_W-1:0] M_OUT = ADDR_W'(ALIAS_OFS + 'h20);

    logic [NUM_PINS-1:0] wmask, wvals;
    assign wmask = bus_wdata[8 +: NUM_PINS];
    assign wvals = bus_wdata[NUM_PINS-1:0];

    p_direct_level_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == D_OUT) |=> (pad_out == $past(wvals)));

    p_masked_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == M_OUT) |=>
            ((pad_out & ~$past(wmask)) == ($past(pad_out) & ~$past(wmask))));

    p_masked_take_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == M_OUT) |=>
            ((pad_out & $past(wmask)) == ($past(wvals) & $past(wmask))));

    p_alias_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && (bus_addr == M_CNF || bus_addr == M_OE || bus_addr == M_OUT))
            |=> (bus_rdata == 32'd0));

    p_input_readonly_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == D_IN) |=> ($stable(pad_out) && $stable(pad_oe)));

    p_release_gates_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == M_CNF && (wmask & ~wvals) != '0) |=>
            ((pad_oe & $past(wmask & ~wvals)) == '0));

    p_idle_rdata_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |=> (bus_rdata == 32'd0));

endmodule

bind gpio_port_regs gpio_port_regs_checker #(
    .NUM_PINS  (NUM_PINS),
    .ADDR_W    (ADDR_W),
    .ALIAS_OFS (ALIAS_OFS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] m_cnf = '0, m_oe = '0, m_out = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_regs u_gpio_port_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] m,
                                         input logic [7:0] v);
        return (old & ~m) | (v & m);
    endfunction

    task automatic check_state(input string req);
        logic [31:0] d;
        bus_read(8'h00, d); check({req, " configure readback"}, d, {24'd0, m_cnf});
        bus_read(8'h10, d); check({req, " drive-enable readback"}, d, {24'd0, m_oe});
        bus_read(8'h20, d); check({req, " level readback"}, d, {24'd0, m_out});
        check({req, " R8 pad_out"}, {24'd0, pad_out}, {24'd0, m_out});
        check({req, " R7 pad_oe"}, {24'd0, pad_oe}, {24'd0, m_cnf & m_oe});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        logic [7:0]  v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 rdata", bus_rdata, 32'd0);
        check("R1 pad_oe", {24'd0, pad_oe}, 32'd0);
        check("R1 pad_out", {24'd0, pad_out}, 32'd0);
        check_state("R1");

        // R2: direct writes to all three
        bus_write(8'h00, 32'hFFFF_FF5A); m_cnf = 8'h5A;
        bus_write(8'h10, 32'h0000_33C3); m_oe  = 8'hC3;
        bus_write(8'h20, 32'hABCD_0096); m_out = 8'h96;
        check_state("R2");

        // R3: sweep every mask through each alias
        for (int r = 0; r < 3; r++) begin
            for (int m = 0; m < 256; m++) begin
                v = 8'((m * 37 + r * 91 + 11) & 255);
                bus_write(8'(8'h80 + r * 16), {16'hA5A5, 8'(m), v});
                case (r)
                    0: m_cnf = merge(m_cnf, 8'(m), v);
                    1: m_oe  = merge(m_oe,  8'(m), v);
                    default: m_out = merge(m_out, 8'(m), v);
                endcase
                check("R3 pad_out", {24'd0, pad_out}, {24'd0, m_out});
                check("R7 pad_oe", {24'd0, pad_oe}, {24'd0, m_cnf & m_oe});
            end
            check_state("R3");
        end

        // R7: configure sweep against derived drive-enable
        for (int c = 0; c < 256; c++) begin
            m_oe = 8'((c * 5 + 3) & 255);
            m_cnf = 8'(c);
            bus_write(8'h10, {24'd0, m_oe});
            bus_write(8'h00, {24'd0, m_cnf});
            check("R7 gate", {24'd0, pad_oe}, {24'd0, m_cnf & m_oe});
        end

        // R4: alias reads return zero
        bus_read(8'h80, d); check("R4 alias cnf", d, 32'd0);
        bus_read(8'h90, d); check("R4 alias oe", d, 32'd0);
        bus_read(8'hA0, d); check("R4 alias out", d, 32'd0);

        // R5: unmapped reads and writes
        bus_read(8'h04, d); check("R5 read 04", d, 32'd0);
        bus_read(8'h40, d); check("R5 read 40", d, 32'd0);
        bus_read(8'hB0, d); check("R5 read B0", d, 32'd0);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h40, 32'hFFFF_FFFF);
        bus_write(8'hB0, 32'hFFFF_FFFF);
        bus_write(8'hF0, 32'h0000_FF00);
        check_state("R5");

        // R6: synchronizer latency and read-only input
        pad_in = 8'h3C;
        bus_read(8'h30, d); check("R6 edge N", d, 32'd0);
        bus_read(8'h30, d); check("R6 edge N+1", d, 32'd0);
        bus_read(8'h30, d); check("R6 edge N+2", d, 32'h3C);
        pad_in = 8'hC5;
        repeat (2) @(negedge clk);
        bus_read(8'h30, d); check("R6 settled", d, 32'hC5);
        bus_write(8'h30, 32'hFFFF_FFFF);
        check_state("R6");
        bus_read(8'h30, d); check("R6 after write", d, 32'hC5);

        // R9: no read -> zero, upper bits zero
        bus_read(8'h30, d);
        @(negedge clk);
        check("R9 idle rdata", bus_rdata, 32'd0);
        bus_write(8'h20, 32'hFFFF_FFFF); m_out = 8'hFF;
        bus_read(8'h20, d); check("R9 upper zero", d, 32'h0000_00FF);

        // R1: reset again clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_cnf = '0; m_oe = '0; m_out = '0;
        check("R1 rdata after reset", bus_rdata, 32'd0);
        check_state("R1 second reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule